// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short queue of one-byte records, one per finished transmission that the host has to hear about, and always shows the oldest record on its status output. The transmit engine reports each finished frame with a one-cycle completion pulse. The pulse carries three error flags (jabber, underrun, too many collisions) and a flag saying that an interrupt on success was requested. A frame that succeeded is recorded only when that interrupt flag is set. A frame with any error is always recorded.

The host reads the status byte. A host write strobe then discards the oldest record and brings the next one forward. When the queue is full, a further record is dropped and the overflow is noted inside the record already at the head. The block raises a transmit-complete event while any record is waiting.

It also keeps the transmitter's enable state. A completion that reports a jabber or an underrun latches a needs-reset flag. While that flag is set the transmitter is held disabled until a transmit-reset command arrives or the block is reset. Commands arrive as 16-bit words, with the opcode in bits 15:11.

Top module: `txstat_stack`

## Requirements
- R1: A stored record has bit 7 set (complete), bit 6 = interrupt-on-success requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow (0 when first stored), and bits 1:0 = 0.
- R2: A completion pulse is stored only when at least one of jabber, underrun or maximum collisions is set, or when the interrupt request is set. A clean completion without the interrupt request leaves the queue unchanged.
- R3: Records are presented oldest first. Each host write strobe removes the record at the head, and the next record appears on the following cycle.
- R4: While the queue is empty the status output reads 0x00, and a host write strobe has no effect.
- R5: With DEPTH (default 4) records held, a storable completion that arrives without a simultaneous pop is discarded, and bit 2 of the head record becomes 1.
- R6: The transmit-complete event output is 1 exactly when at least one record is held.
- R7: A completion with jabber or underrun sets the needs-reset output and forces the transmitter to disabled. A transmit-enable command has no effect while needs-reset is set.
- R8: Commands use opcode bits 15:11: 0x09 enables the transmitter, 0x0A disables it, and 0x0B (transmit reset) empties the queue, clears needs-reset and leaves the transmitter disabled. A transmit reset takes priority over a completion or pop in the same cycle. Other opcodes are ignored.
- R9: After reset the queue is empty, the transmitter is disabled and needs-reset is 0.
- R10: When the queue is full, a pop and a storable completion in the same cycle both take effect, and no overflow is marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | Completion pulse from the transmit engine |
| cmp_jabber | input | 1 | Completion ended with a jabber error |
| cmp_underrun | input | 1 | Completion ended with an underrun |
| cmp_maxcoll | input | 1 | Completion hit the collision limit |
| cmp_irq_req | input | 1 | Interrupt on success requested |
| host_pop | input | 1 | Host write strobe to the status register (pops the head) |
| host_status | output | 8 | Head record, or 0x00 when empty |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Command word, opcode in bits 15:11 |
| txc_event | output | 1 | Transmit-complete event, records waiting |
| tx_needs_reset | output | 1 | Jabber or underrun seen since the last reset |
| tx_enabled | output | 1 | Transmitter enable state |

## Verification
All sixteen combinations of the three error flags and the interrupt request are pushed into an empty queue one at a time. This separates the storage rule (clean completions without an interrupt request are dropped) from the bit encoding of each flag. Runs of six numbered completions fill the queue past its depth, and then a drain checks oldest-first order and the overflow mark on the head. A pop that coincides with a push on a full queue tells "slot freed first" apart from "overflow". Command sequences mix enable, disable and unknown opcodes with fatal completions, so the lock set by a jabber or an underrun is tested against both kinds of reset.

// File: rtl/txstat_pkg.sv
// Shared definitions for the transmit completion status stack.
// Assumes an 8-bit record and a 5-bit opcode in bits 15:11 of a command word.
package txstat_pkg;

    localparam int REC_W = 8;

    localparam logic [4:0] OP_TX_ENABLE  = 5'h09;
    localparam logic [4:0] OP_TX_DISABLE = 5'h0A;
    localparam logic [4:0] OP_TX_RESET   = 5'h0B;

    localparam int BIT_OVF = 2;

    // Build a fresh record from the completion flags (overflow starts clear).
    function automatic logic [REC_W-1:0] make_record(
        input logic irq_req, input logic jabber,
        input logic underrun, input logic maxcoll);
        make_record = {1'b1, irq_req, jabber, underrun, maxcoll, 3'b000};
    endfunction

endpackage

// File: rtl/txstat_queue.sv
// Record queue: first-in first-out storage of DEPTH records.
// A pop is applied before a push in the same cycle, so a full queue with a
// pop accepts the new record. A push into a full queue without a pop is
// dropped and marks the overflow bit of the head record. Flush empties it.
// Assumes DEPTH >= 2.
module txstat_queue
    import txstat_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [REC_W-1:0] wdata,
    input  logic             pop,
    output logic [REC_W-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [REC_W-1:0] mem [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    count;
    logic             pop_ok, push_ok, ovf_mark;

    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign pop_ok   = pop && !empty;
    assign push_ok  = push && (!full || pop_ok);
    assign ovf_mark = push && full && !pop_ok;
    assign head     = mem[rd_ptr];

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Record storage, including the overflow mark on the head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (!flush) begin
            if (push_ok)  mem[wr_ptr] <= wdata;
            if (ovf_mark) mem[rd_ptr][BIT_OVF] <= 1'b1;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (full && head[BIT_OVF])); // R5
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && pop && !flush) |=> full); // R10
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R8
    AST_HEAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |-> head[REC_W-1]); // R1

endmodule

// File: rtl/txstat_ctrl.sv
// Transmitter enable and reset-lock control.
// Decodes the command opcode and keeps the enable state and the needs-reset
// lock that a jabber or underrun completion sets. Assumes one command per
// cycle at most.
module txstat_ctrl
    import txstat_pkg::*;
#(
    parameter int CMD_W = 16,
    parameter int OP_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             fatal_seen,
    output logic             flush,
    output logic             needs_reset,
    output logic             enabled
);
    logic [OP_W-1:0] opcode;
    logic            op_en, op_dis, lock_next;

    assign opcode    = cmd_word[CMD_W-1 -: OP_W];
    assign flush     = cmd_valid && (opcode == OP_TX_RESET);
    assign op_en     = cmd_valid && (opcode == OP_TX_ENABLE);
    assign op_dis    = cmd_valid && (opcode == OP_TX_DISABLE);
    assign lock_next = !flush && (needs_reset || fatal_seen);

    // Lock and enable state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            needs_reset <= 1'b0;
            enabled     <= 1'b0;
        end else begin
            needs_reset <= lock_next;
            if (lock_next || flush || op_dis) enabled <= 1'b0;
            else if (op_en)                    enabled <= 1'b1;
        end
    end

    AST_LOCK_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        needs_reset |-> !enabled); // R7
    AST_FATAL_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal_seen && !flush) |=> needs_reset); // R7
    AST_RESET_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!needs_reset && !enabled)); // R8

endmodule

// File: rtl/txstat_stack.sv
// Transmit completion status stack, top level.
// Filters completion pulses, queues their records, presents the head to the
// host (0x00 when empty) and drives the transmit-complete event and the
// transmitter enable state. Assumes completion pulses last one cycle.
module txstat_stack
    import txstat_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_valid,
    input  logic             cmp_jabber,
    input  logic             cmp_underrun,
    input  logic             cmp_maxcoll,
    input  logic             cmp_irq_req,
    input  logic             host_pop,
    output logic [REC_W-1:0] host_status,
    input  logic             cmd_valid,
    input  logic [15:0]      cmd_word,
    output logic             txc_event,
    output logic             tx_needs_reset,
    output logic             tx_enabled
);
    logic             any_err, store, fatal, flush, q_empty, q_full;
    logic [REC_W-1:0] rec, q_head;

    assign any_err = cmp_jabber || cmp_underrun || cmp_maxcoll;
    assign store   = cmp_valid && (any_err || cmp_irq_req);
    assign fatal   = cmp_valid && (cmp_jabber || cmp_underrun);
    assign rec     = make_record(cmp_irq_req, cmp_jabber, cmp_underrun, cmp_maxcoll);

    txstat_queue #(.DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (store),
        .wdata (rec),
        .pop   (host_pop),
        .head  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    txstat_ctrl #(.CMD_W(16), .OP_W(5)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_word    (cmd_word),
        .fatal_seen  (fatal),
        .flush       (flush),
        .needs_reset (tx_needs_reset),
        .enabled     (tx_enabled)
    );

    assign host_status = q_empty ? '0 : q_head;
    assign txc_event   = !q_empty;

    AST_CLEAN_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty && cmp_valid && !any_err && !cmp_irq_req && !flush)
        |=> !txc_event); // R2
    AST_STORE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (store && !flush) |=> txc_event); // R6
    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_status[1:0] == 2'b00); // R1

endmodule

// File: tb/sim_txstat_stack.sv
module sim_txstat_stack;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 0, cmp_jabber = 0, cmp_underrun = 0, cmp_maxcoll = 0, cmp_irq_req = 0;
    logic        host_pop = 0, cmd_valid = 0;
    logic [15:0] cmd_word = '0;
    logic [7:0]  host_status;
    logic        txc_event, tx_needs_reset, tx_enabled;

    int n_checks = 0, n_fail = 0;

    // Reference model state.
    logic [7:0] mq[$];
    logic       m_lock = 0, m_en = 0;

    always #2.5 clk = ~clk;

    txstat_stack #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmp_valid(cmp_valid), .cmp_jabber(cmp_jabber), .cmp_underrun(cmp_underrun),
        .cmp_maxcoll(cmp_maxcoll), .cmp_irq_req(cmp_irq_req),
        .host_pop(host_pop), .host_status(host_status),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .txc_event(txc_event), .tx_needs_reset(tx_needs_reset), .tx_enabled(tx_enabled)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: flags = {jabber, underrun, maxcoll, irq}; opcode in cmd bits 15:11.
    task automatic step(input string tag, input logic c, input logic [3:0] f,
                        input logic pop, input logic cv, input logic [4:0] op);
        logic [7:0] e;
        logic       stor;
        @(negedge clk);
        cmp_valid = c; {cmp_jabber, cmp_underrun, cmp_maxcoll, cmp_irq_req} = f;
        host_pop = pop; cmd_valid = cv; cmd_word = {op, 11'h2A5};
        // model
        if (cv && op == 5'h0B) begin
            mq.delete(); m_lock = 0; m_en = 0;
        end else begin
            if (pop && mq.size() > 0) void'(mq.pop_front());
            stor = c && (f != 4'b0000);
            e = {1'b1, f[0], f[3], f[2], f[1], 3'b000};
            if (stor) begin
                if (mq.size() < DEPTH) mq.push_back(e);
                else mq[0][2] = 1'b1;
            end
            if (c && (f[3] || f[2])) m_lock = 1;
            if (m_lock || (cv && op == 5'h0A)) m_en = 0;
            else if (cv && op == 5'h09) m_en = 1;
        end
        @(negedge clk);
        cmp_valid = 0; host_pop = 0; cmd_valid = 0;
        chk(tag, host_status, (mq.size() > 0) ? mq[0] : 8'h00);
        chk("R6 event", {7'd0, txc_event}, {7'd0, mq.size() > 0});
        chk("R7 needs_reset", {7'd0, tx_needs_reset}, {7'd0, m_lock});
        chk("R8 enabled", {7'd0, tx_enabled}, {7'd0, m_en});
    endtask

    task automatic idle_check(input string tag);
        step(tag, 0, 4'b0, 0, 0, 5'h00);
    endtask

    initial begin
        #5000000;
        n_fail++; n_checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle_check("R9 reset state");
        // R1 R2: sweep all flag combinations into an empty queue.
        for (int f = 0; f < 16; f++) begin
            step("R1 R2 encode", 1, 4'(f), 0, 0, 5'h00);
            step("R3 pop", 0, 4'b0, 1, 0, 5'h00);
            step("R8 reset clears lock", 0, 4'b0, 0, 1, 5'h0B);
        end
        // R4: pop on empty.
        step("R4 empty pop", 0, 4'b0, 1, 0, 5'h00);
        // R8: enable, unknown opcode, disable.
        step("R8 enable", 0, 4'b0, 0, 1, 5'h09);
        step("R8 unknown op", 0, 4'b0, 0, 1, 5'h03);
        step("R8 disable", 0, 4'b0, 0, 1, 5'h0A);
        step("R8 enable again", 0, 4'b0, 0, 1, 5'h09);
        // R5: fill past depth with maxcoll/irq mixes, then drain.
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < 6; k++)
                step("R5 fill", 1, {2'b00, 1'(k), 1'b1}, 0, 0, 5'h00);
            for (int k = 0; k < DEPTH + 1; k++)
                step("R3 R5 drain", 0, 4'b0, 1, 0, 5'h00);
        end
        // R10: full queue, pop and push together.
        for (int k = 0; k < DEPTH; k++) step("R10 fill", 1, 4'b0011, 0, 0, 5'h00);
        step("R10 swap", 1, 4'b0001, 1, 0, 5'h00);
        step("R10 swap2", 1, 4'b0010, 1, 0, 5'h00);
        for (int k = 0; k < DEPTH; k++) step("R10 drain", 0, 4'b0, 1, 0, 5'h00);
        // R7: underrun locks; enable ignored; reset unlocks.
        step("R7 underrun", 1, 4'b0100, 0, 1, 5'h09);
        step("R7 enable blocked", 0, 4'b0, 0, 1, 5'h09);
        step("R7 jabber", 1, 4'b1000, 0, 0, 5'h00);
        step("R8 reset with push", 1, 4'b0001, 1, 1, 5'h0B);
        step("R8 enable after reset", 0, 4'b0, 0, 1, 5'h09);
        // R2: clean completions without irq are skipped.
        for (int k = 0; k < 3; k++) step("R2 clean skip", 1, 4'b0000, 0, 0, 5'h00);
        // R9: global reset mid-traffic.
        step("R9 pre", 1, 4'b1001, 0, 0, 5'h00);
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        mq.delete(); m_lock = 0; m_en = 0;
        idle_check("R9 after global reset");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule